// File: doc/BRIEF.md
# Transmit descriptor gather engine

This block walks a ring of 8-byte transmit descriptors held in host memory. Each valid descriptor points at a buffer fragment. The engine copies the fragment's bytes into an on-chip staging buffer, appending each fragment after the bytes already there. When it reaches a descriptor flagged as the final fragment, it streams the assembled frame out one byte per beat on a valid/ready interface. Every descriptor it consumes is written back with its ownership and error flags cleared.

Software sets the ring base, the ring size field and then rings the doorbell. One pass resumes where the previous pass stopped. It ends at the first descriptor that is not owned by the engine, or after one full lap of the ring. A control reset returns both ring pointers to the base and discards any partially staged frame. An interrupt flag reports that at least one frame left during the pass.

Top module: `tx_gather_engine`

## Requirements
- R1: After reset, `idle` is 1, `out_valid` is 0, `tx_irq` is 0, and both `cur_desc_ptr` and `next_desc_ptr` are 0.
- R2: A pass starts at `next_desc_ptr` when the whole descriptor at that address lies inside the ring, which spans from `ring_base` up to `ring_base + 8*(ring_size_field+1)`. Otherwise the pass starts at `ring_base`. `cur_desc_ptr` follows the descriptor being examined, and after the pass it holds the last descriptor examined.
- R3: Each descriptor has two 32-bit words. The word at +0 holds the buffer byte address. The word at +4 holds the length minus one in bits 15:0 and the flags in bits 31:16. Flag bit 15 is the ownership (valid) bit. A pass stops at the first descriptor whose valid bit is clear, leaves that descriptor unwritten and does not advance `next_desc_ptr` past it. A pass examines at most `ring_size_field+1` descriptors.
- R4: Each valid descriptor supplies length+1 bytes, read from its buffer in ascending address order. Memory words are little-endian, so byte address a sits in bits 8*(a mod 4) of its word. These bytes are appended to the staged frame. Flag bit 0 marks the last fragment, and the staged bytes then leave in order as one frame.
- R5: The write-back of the word at +4 keeps the length field. It clears flag bits 15 to 9 (valid, error, underflow, late collision, carrier lost, deferred, retry error) and keeps all other flag bits.
- R6: After each descriptor the engine consumes, `next_desc_ptr` advances by 8. When it reaches the ring end, it wraps to `ring_base`.
- R7: At the end of a pass, `tx_irq` is set if and only if at least one frame was sent during that pass. It then holds until `irq_ack` is pulsed.
- R8: `idle` falls in the cycle after an accepted doorbell and stays low until the pass ends. This includes the time a frame is stalled downstream.
- R9: A `ctrl_reset` pulse sets both pointers to `ring_base` by the next cycle, abandons any pass, and discards the staged bytes.
- R10: A fragment that would push the staged byte count past `STAGE_DEPTH` discards the partial frame. Its write-back also sets flag bits 14 and 13, and staging restarts at offset zero.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady. `out_last` marks the final byte of each frame. The ring walk does not advance until that byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | Byte address of descriptor 0 |
| ring_size_field | input | SZW | Descriptor count minus one |
| doorbell | input | 1 | Starts a pass when the engine is idle |
| ctrl_reset | input | 1 | Rewinds the pointers and drops staged bytes |
| irq_ack | input | 1 | Clears the transmit interrupt flag |
| idle | output | 1 | High while no pass is running |
| tx_irq | output | 1 | Sticky frame-sent interrupt flag |
| cur_desc_ptr | output | AW | Address of the descriptor being or last examined |
| next_desc_ptr | output | AW | Address where the next pass resumes |
| mem_rd_en | output | 1 | Host memory read strobe |
| mem_rd_addr | output | AW | Host memory read byte address |
| mem_rd_data | input | 32 | Read word, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Host memory write strobe |
| mem_wr_addr | output | AW | Host memory write byte address (word aligned) |
| mem_wr_data | output | 32 | Host memory write word |
| out_valid | output | 1 | Frame byte available |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of a frame |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
- A staging offset that is not cleared shows up in the next frame: it carries extra leading bytes or loses bytes at the front, and this is visible on the first beat that is compared.
- A pointer that wraps at the wrong place, or that skips its bounds check, has two visible effects. The wrong descriptor's flags are written back, and `next_desc_ptr` settles at an unexpected address. Both can be read as soon as `idle` returns.
- A wrong clear mask in the write-back is visible in the host memory word right after the pass.
- A lost pass-level flag surfaces on `tx_irq` in the cycle after the pass ends.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  localparam int DESC_BYTES = 8;

  // Flag bit positions inside the upper half of descriptor word 1
  localparam int F_VALID = 15;
  localparam int F_ERR   = 14;
  localparam int F_UNDER = 13;
  localparam int F_LATE  = 12;
  localparam int F_CARR  = 11;
  localparam int F_DEFER = 10;
  localparam int F_RETRY = 9;
  localparam int F_LAST  = 0;

  localparam logic [15:0] WB_CLEAR_MASK =
    16'((1 << F_VALID) | (1 << F_ERR) | (1 << F_UNDER) | (1 << F_LATE) |
        (1 << F_CARR) | (1 << F_DEFER) | (1 << F_RETRY));
  localparam logic [15:0] OVF_SET_MASK = 16'((1 << F_ERR) | (1 << F_UNDER));

  typedef enum logic [3:0] {
    S_IDLE, S_D0, S_D1, S_DCHK, S_FRD, S_FWR, S_WB, S_EMIT, S_ADV, S_DONE
  } eng_state_t;

  typedef enum logic [1:0] {E_IDLE, E_RD, E_LD, E_HOLD} emit_state_t;
endpackage

// File: rtl/tdg_ring_ptr.sv
module tdg_ring_ptr #(
  parameter int AW  = 16,
  parameter int SZW = 8
) (
  input  logic [AW-1:0]  base,
  input  logic [SZW-1:0] size_field,
  input  logic [AW-1:0]  ptr,
  output logic           in_ring,
  output logic [AW-1:0]  ptr_fixed,
  output logic [AW-1:0]  ptr_adv
);
  localparam int EW = AW + 1;

  logic [EW-1:0] span, ring_end, p_ext, p_nxt;

  always_comb begin
    span     = EW'({size_field, 3'b000}) + EW'(tdg_pkg::DESC_BYTES);
    ring_end = {1'b0, base} + span;
    p_ext    = {1'b0, ptr};
    p_nxt    = p_ext + EW'(tdg_pkg::DESC_BYTES);
    in_ring  = (p_ext >= {1'b0, base}) && (p_nxt <= ring_end);
    ptr_fixed = in_ring ? ptr : base;
    ptr_adv   = (p_nxt >= ring_end) ? base : ptr + AW'(tdg_pkg::DESC_BYTES);
  end
endmodule

// File: rtl/tdg_stage_ram.sv
module tdg_stage_ram #(
  parameter int DEPTH = 256,
  parameter int RAW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [7:0]     wdata,
  input  logic [RAW-1:0] raddr,
  output logic [7:0]     q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/tdg_emitter.sv
module tdg_emitter #(
  parameter int OW  = 9,
  parameter int RAW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           start,
  input  logic [OW-1:0]  frame_len,
  output logic [RAW-1:0] ram_raddr,
  input  logic [7:0]     ram_q,
  output logic           out_valid,
  output logic [7:0]     out_data,
  output logic           out_last,
  input  logic           out_ready,
  output logic           done
);
  import tdg_pkg::*;

  emit_state_t   est;
  logic [OW-1:0] idx, len_q;

  assign ram_raddr = idx[RAW-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      est       <= E_IDLE;
      idx       <= '0;
      len_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (est)
        E_IDLE: if (start) begin
          idx   <= '0;
          len_q <= frame_len;
          est   <= E_RD;
        end
        E_RD: est <= E_LD;
        E_LD: begin
          out_valid <= 1'b1;
          out_data  <= ram_q;
          out_last  <= (idx == len_q - OW'(1));
          est       <= E_HOLD;
        end
        E_HOLD: if (out_ready) begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
          if (out_last) begin
            done <= 1'b1;
            est  <= E_IDLE;
          end else begin
            idx <= idx + OW'(1);
            est <= E_RD;
          end
        end
        default: est <= E_IDLE;
      endcase
    end
  end

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst || clr)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R11
endmodule

// File: rtl/tx_gather_engine.sv
module tx_gather_engine #(
  parameter int AW          = 16,
  parameter int SZW         = 8,
  parameter int STAGE_DEPTH = 256
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  ring_base,
  input  logic [SZW-1:0] ring_size_field,
  input  logic           doorbell,
  input  logic           ctrl_reset,
  input  logic           irq_ack,
  output logic           idle,
  output logic           tx_irq,
  output logic [AW-1:0]  cur_desc_ptr,
  output logic [AW-1:0]  next_desc_ptr,
  output logic           mem_rd_en,
  output logic [AW-1:0]  mem_rd_addr,
  input  logic [31:0]    mem_rd_data,
  output logic           mem_wr_en,
  output logic [AW-1:0]  mem_wr_addr,
  output logic [31:0]    mem_wr_data,
  output logic           out_valid,
  output logic [7:0]     out_data,
  output logic           out_last,
  input  logic           out_ready
);
  import tdg_pkg::*;

  localparam int OW  = $clog2(STAGE_DEPTH + 1);
  localparam int RAW = $clog2(STAGE_DEPTH);
  localparam int LW  = 17;

  eng_state_t     st;
  logic [AW-1:0]  buf_q;
  logic [15:0]    len_q, flags_q;
  logic [LW-1:0]  len1_q, k_q, dchk_len1;
  logic [OW-1:0]  off_q;
  logic [SZW:0]   cnt_q;
  logic           sent_q, ovf_q, irq_q;
  logic [1:0]     lane_q;

  logic [AW-1:0]  rp_in, rp_fixed, rp_adv;
  logic           rp_in_ring;

  logic           ram_we;
  logic [RAW-1:0] ram_waddr, ram_raddr;
  logic [7:0]     ram_wdata, ram_q;
  logic           emit_start, emit_done;

  // Pointer arithmetic: validates the resume pointer while idle, steps cur otherwise
  assign rp_in = (st == S_IDLE) ? next_desc_ptr : cur_desc_ptr;

  tdg_ring_ptr #(.AW(AW), .SZW(SZW)) u_ring_ptr (
    .base       (ring_base),
    .size_field (ring_size_field),
    .ptr        (rp_in),
    .in_ring    (rp_in_ring),
    .ptr_fixed  (rp_fixed),
    .ptr_adv    (rp_adv)
  );

  tdg_stage_ram #(.DEPTH(STAGE_DEPTH), .RAW(RAW)) u_stage (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .q     (ram_q)
  );

  tdg_emitter #(.OW(OW), .RAW(RAW)) u_emit (
    .clk       (clk),
    .rst       (rst),
    .clr       (ctrl_reset),
    .start     (emit_start),
    .frame_len (off_q),
    .ram_raddr (ram_raddr),
    .ram_q     (ram_q),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready),
    .done      (emit_done)
  );

  // Host memory requests are decoded from the registered state
  always_comb begin
    mem_rd_en   = 1'b0;
    mem_rd_addr = '0;
    case (st)
      S_D0:  begin mem_rd_en = 1'b1; mem_rd_addr = cur_desc_ptr; end
      S_D1:  begin mem_rd_en = 1'b1; mem_rd_addr = cur_desc_ptr + AW'(4); end
      S_FRD: begin mem_rd_en = 1'b1; mem_rd_addr = buf_q + AW'(k_q); end
      default: ;
    endcase
    mem_wr_en   = (st == S_WB);
    mem_wr_addr = cur_desc_ptr + AW'(4);
    mem_wr_data = {(flags_q & ~WB_CLEAR_MASK) | (ovf_q ? OVF_SET_MASK : 16'h0000), len_q};
  end

  assign dchk_len1  = LW'(mem_rd_data[15:0]) + LW'(1);
  assign ram_we     = (st == S_FWR);
  assign ram_waddr  = RAW'(LW'(off_q) + k_q);
  assign ram_wdata  = 8'(mem_rd_data >> {lane_q, 3'b000});
  assign emit_start = (st == S_WB) && flags_q[F_LAST] && !ovf_q;
  assign idle       = (st == S_IDLE);
  assign tx_irq     = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      cur_desc_ptr  <= '0;
      next_desc_ptr <= '0;
      buf_q         <= '0;
      len_q         <= '0;
      flags_q       <= '0;
      len1_q        <= '0;
      k_q           <= '0;
      off_q         <= '0;
      cnt_q         <= '0;
      sent_q        <= 1'b0;
      ovf_q         <= 1'b0;
      irq_q         <= 1'b0;
      lane_q        <= '0;
    end else begin
      if (irq_ack) irq_q <= 1'b0;
      if (ctrl_reset) begin
        st            <= S_IDLE;
        off_q         <= '0;
        cur_desc_ptr  <= ring_base;
        next_desc_ptr <= ring_base;
        sent_q        <= 1'b0;
        ovf_q         <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (doorbell) begin
            cur_desc_ptr <= rp_fixed;
            cnt_q        <= '0;
            sent_q       <= 1'b0;
            st           <= S_D0;
          end
          S_D0: st <= S_D1;
          S_D1: begin
            buf_q <= mem_rd_data[AW-1:0];
            st    <= S_DCHK;
          end
          S_DCHK: begin
            len_q   <= mem_rd_data[15:0];
            flags_q <= mem_rd_data[31:16];
            len1_q  <= dchk_len1;
            k_q     <= '0;
            ovf_q   <= 1'b0;
            if (!mem_rd_data[16 + F_VALID]) begin
              st <= S_DONE;
            end else if ((LW+1)'(off_q) + (LW+1)'(dchk_len1) > (LW+1)'(STAGE_DEPTH)) begin
              ovf_q <= 1'b1;
              off_q <= '0;
              st    <= S_WB;
            end else begin
              st <= S_FRD;
            end
          end
          S_FRD: begin
            lane_q <= mem_rd_addr[1:0];
            st     <= S_FWR;
          end
          S_FWR: begin
            if (k_q == len1_q - LW'(1)) begin
              off_q <= OW'(LW'(off_q) + len1_q);
              st    <= S_WB;
            end else begin
              k_q <= k_q + LW'(1);
              st  <= S_FRD;
            end
          end
          S_WB: st <= emit_start ? S_EMIT : S_ADV;
          S_EMIT: if (emit_done) begin
            off_q  <= '0;
            sent_q <= 1'b1;
            st     <= S_ADV;
          end
          S_ADV: begin
            next_desc_ptr <= rp_adv;
            cnt_q         <= cnt_q + (SZW+1)'(1);
            if (cnt_q == {1'b0, ring_size_field}) begin
              st <= S_DONE;
            end else begin
              cur_desc_ptr <= rp_adv;
              st           <= S_D0;
            end
          end
          S_DONE: begin
            if (sent_q) irq_q <= 1'b1;
            st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_WB_VALID_CLEAR: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> !mem_wr_data[16 + F_VALID]); // R5
  AST_OVF_FLAGS: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en && ovf_q |-> mem_wr_data[16 + F_ERR] && mem_wr_data[16 + F_UNDER]); // R10
  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (LW+1)'(off_q) <= (LW+1)'(STAGE_DEPTH)); // R10
  AST_NO_STREAM_IDLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !idle); // R8
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_irq) |-> $past(st == S_DONE)); // R7
  AST_CUR_IN_RING: assert property (@(posedge clk) disable iff (rst || ctrl_reset)
    st == S_D0 |-> rp_in_ring); // R2
  AST_CLR_PTRS: assert property (@(posedge clk) disable iff (rst)
    ctrl_reset |=> next_desc_ptr == $past(ring_base) && cur_desc_ptr == $past(ring_base)); // R9
  AST_WALK_FROZEN: assert property (@(posedge clk) disable iff (rst || ctrl_reset)
    st == S_EMIT && $past(st == S_EMIT) |-> $stable(next_desc_ptr)); // R11
endmodule

// File: tb/test_tx_gather_engine.sv
module test_tx_gather_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 16;
  localparam int SZW   = 8;
  localparam int DEPTH = 64;
  localparam logic [15:0] BASE = 16'h0100;
  localparam int MEMW  = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] ring_base = BASE;
  logic [SZW-1:0] ring_size_field = 8'd3;
  logic doorbell = 1'b0, ctrl_reset = 1'b0, irq_ack = 1'b0;
  logic idle, tx_irq, mem_rd_en, mem_wr_en, out_valid, out_last;
  logic out_ready = 1'b0;
  logic [AW-1:0] cur_desc_ptr, next_desc_ptr, mem_rd_addr, mem_wr_addr;
  logic [31:0] mem_rd_data, mem_wr_data;
  logic [7:0] out_data;

  logic [31:0] mem [MEMW];
  logic hw_en = 1'b0;
  logic [15:0] hw_addr = '0;
  logic [31:0] hw_data = '0;

  int checks = 0, fails = 0, cyc = 0;
  logic stall = 1'b0, hold_pend = 1'b0, hold_last;
  logic [7:0] hold_data;
  int rcnt = 0;
  logic [8:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_gather_engine #(.AW(AW), .SZW(SZW), .STAGE_DEPTH(DEPTH)) i_tx_gather_engine (
    .clk(clk), .rst(rst), .ring_base(ring_base), .ring_size_field(ring_size_field),
    .doorbell(doorbell), .ctrl_reset(ctrl_reset), .irq_ack(irq_ack),
    .idle(idle), .tx_irq(tx_irq), .cur_desc_ptr(cur_desc_ptr), .next_desc_ptr(next_desc_ptr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  // Host memory model: one-cycle read latency, word addressed by byte address
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[13:2]];
    if (mem_wr_en) mem[mem_wr_addr[13:2]] <= mem_wr_data;
    if (hw_en) mem[hw_addr[13:2]] <= hw_data;
  end

  function automatic logic [7:0] pat(input logic [15:0] a);
    return 8'(a * 16'd7 + (a >> 5));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic set_desc(input int idx, input logic [15:0] bufa, input logic [15:0] lenf,
                          input logic [15:0] flags);
    host_write(BASE + 16'(8 * idx), {16'h0000, bufa});
    host_write(BASE + 16'(8 * idx + 4), {flags, lenf});
  endtask

  // Driver side of the scoreboard: expected bytes of one fragment
  task automatic push_frag(input logic [15:0] bufa, input int n, input bit last);
    for (int i = 0; i < n; i++)
      exp_q.push_back({last && (i == n - 1), pat(bufa + 16'(i))});
  endtask

  task automatic ring;
    @(negedge clk); doorbell = 1'b1;
    @(negedge clk); doorbell = 1'b0;
  endtask

  task automatic wait_idle;
    while (!idle) @(negedge clk);
  endtask

  task automatic pulse_ack;
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  function automatic logic [31:0] dword1(input int idx);
    return mem[(BASE + 16'(8 * idx + 4)) >> 2];
  endfunction

  // Monitor: picks out_ready, then compares every accepted beat
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend)
        chk(out_valid && out_data == hold_data && out_last == hold_last, "R11 hold",
            {23'd0, out_valid, out_data}, {24'd1, hold_data});
      rcnt++;
      out_ready = !stall && (rcnt % 3 != 1);
      hold_pend = out_valid && !out_ready;
      hold_data = out_data;
      hold_last = out_last;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected byte", {23'd0, out_last, out_data}, 32'h0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({out_last, out_data} == e, "R4/R11 frame byte", {23'd0, out_last, out_data}, {23'd0, e});
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(idle == 1'b1, "R1 idle", 32'(idle), 1);
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    chk(tx_irq == 1'b0, "R1 tx_irq", 32'(tx_irq), 0);
    chk(next_desc_ptr == 0 && cur_desc_ptr == 0, "R1 pointers", 32'(next_desc_ptr), 0);

    for (int w = 0; w < 256; w++) begin
      logic [15:0] a;
      a = 16'h0400 + 16'(w * 4);
      host_write(a, {pat(a + 16'd3), pat(a + 16'd2), pat(a + 16'd1), pat(a)});
    end

    // Pass A: start pointer 0 is outside the ring, so the walk begins at the base
    set_desc(0, 16'h0401, 16'd5, 16'hFF02);
    set_desc(1, 16'h0412, 16'd2, 16'h8001);
    set_desc(2, 16'h0423, 16'd0, 16'h8001);
    set_desc(3, 16'h0430, 16'd7, 16'h0001);
    push_frag(16'h0401, 6, 1'b0);
    push_frag(16'h0412, 3, 1'b1);
    push_frag(16'h0423, 1, 1'b1);
    stall = 1'b1;
    ring();
    while (!out_valid) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(out_valid == 1'b1, "R11 stalled beat kept", 32'(out_valid), 1);
    chk(next_desc_ptr == BASE + 16'd8, "R11 walk frozen", 32'(next_desc_ptr), 32'(BASE + 16'd8));
    chk(idle == 1'b0, "R8 busy while stalled", 32'(idle), 0);
    stall = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R4 frames complete", exp_q.size(), 0);
    chk(next_desc_ptr == BASE + 16'd24, "R3 stop at invalid", 32'(next_desc_ptr), 32'(BASE + 16'd24));
    chk(cur_desc_ptr == BASE + 16'd24, "R2 cur last examined", 32'(cur_desc_ptr), 32'(BASE + 16'd24));
    chk(dword1(0) == 32'h0102_0005, "R2 R5 first desc written back", dword1(0), 32'h0102_0005);
    chk(dword1(1) == 32'h0001_0002, "R5 desc1 write-back", dword1(1), 32'h0001_0002);
    chk(dword1(3) == 32'h0001_0007, "R3 invalid desc untouched", dword1(3), 32'h0001_0007);
    chk(tx_irq == 1'b1, "R7 irq after frames", 32'(tx_irq), 1);
    pulse_ack();
    chk(tx_irq == 1'b0, "R7 irq cleared by ack", 32'(tx_irq), 0);

    // Pass B: resume at desc 3 and wrap to desc 0
    set_desc(3, 16'h0440, 16'd1, 16'h8001);
    set_desc(0, 16'h0450, 16'd0, 16'h8003);
    push_frag(16'h0440, 2, 1'b1);
    push_frag(16'h0450, 1, 1'b1);
    ring();
    wait_idle();
    chk(exp_q.size() == 0, "R4 wrapped frames", exp_q.size(), 0);
    chk(next_desc_ptr == BASE + 16'd8, "R6 wrap to base", 32'(next_desc_ptr), 32'(BASE + 16'd8));
    chk(dword1(0) == 32'h0003_0000, "R5 keep other flags", dword1(0), 32'h0003_0000);
    chk(tx_irq == 1'b1, "R7 irq pass B", 32'(tx_irq), 1);
    pulse_ack();

    // Pass C: all four owned, none last, so one full lap and no frame
    set_desc(1, 16'h0460, 16'd0, 16'h8000);
    set_desc(2, 16'h0461, 16'd0, 16'h8000);
    set_desc(3, 16'h0462, 16'd0, 16'h8000);
    set_desc(0, 16'h0463, 16'd0, 16'h8000);
    ring();
    wait_idle();
    chk(next_desc_ptr == BASE + 16'd8, "R3 one lap max", 32'(next_desc_ptr), 32'(BASE + 16'd8));
    chk(cur_desc_ptr == BASE, "R3 last examined desc0", 32'(cur_desc_ptr), 32'(BASE));
    chk(tx_irq == 1'b0, "R7 no irq without frame", 32'(tx_irq), 0);

    @(negedge clk); ctrl_reset = 1'b1;
    @(negedge clk); ctrl_reset = 1'b0;
    chk(next_desc_ptr == BASE && cur_desc_ptr == BASE, "R9 pointers to base",
        32'(next_desc_ptr), 32'(BASE));
    set_desc(0, 16'h0470, 16'd0, 16'h8001);
    push_frag(16'h0470, 1, 1'b1);
    ring();
    wait_idle();
    chk(exp_q.size() == 0, "R9 staged bytes discarded", exp_q.size(), 0);
    chk(next_desc_ptr == BASE + 16'd8, "R9 walk from base", 32'(next_desc_ptr), 32'(BASE + 16'd8));
    pulse_ack();

    // Pass D: 50 + 20 bytes exceed a 64-byte stage
    set_desc(1, 16'h0480, 16'd49, 16'h8000);
    set_desc(2, 16'h04C0, 16'd19, 16'h8001);
    set_desc(3, 16'h04E0, 16'd2, 16'h8001);
    push_frag(16'h04E0, 3, 1'b1);
    ring();
    wait_idle();
    chk(dword1(2) == 32'h6001_0013, "R10 overflow flags", dword1(2), 32'h6001_0013);
    chk(exp_q.size() == 0, "R10 only next frame sent", exp_q.size(), 0);
    chk(tx_irq == 1'b1, "R7 R10 irq after recovery", 32'(tx_irq), 1);
    chk(next_desc_ptr == BASE, "R6 stop wrapped at desc0", 32'(next_desc_ptr), 32'(BASE));

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule